// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a single-port synchronous static memory. Each word is 18 bits wide and is split into two 9-bit byte lanes. Address, select, write-control and write-data inputs take effect on the rising clock edge. Read data is held in an output register before it reaches the bus, which gives a two-edge read pipeline.

An access opens when either of two address strobes is sampled low. On that edge the block latches the address. It also latches whether all three chip selects are in their active states. A two-bit wrap-around counter then produces the low address bits for the rest of a four-beat burst, in linear or interleaved order. Writes can target one lane, both lanes, or neither, and a global write input forces both lanes. The output enable acts without the clock.

The shared data bus is split at the block edge into `data_i`, `data_o` and a drive enable `data_oe`, which the pad ring uses to form the common bus. A sleep input freezes the block and releases the bus. Stored contents are kept through sleep.

Top module: `burst_sram`

## Requirements
- R1: A read whose address is sampled on edge N shows its word on `data_o` with `data_oe` high after edge N+1, and not after edge N. This assumes the output enable is active and the read is not masked.
- R2: Lane 0 is bits {16, 7:0} and lane 1 is bits {17, 15:8}. With `bwe_n` low and `gwe_n` high, a word is written only in lanes k where `lane_we_n[k]` is low; the other lane keeps its stored value.
- R3: With `gwe_n` low, both lanes are written, whatever `bwe_n` and `lane_we_n` are.
- R4: With `gwe_n` and `bwe_n` both high, the cycle is a read and the memory is unchanged, even if `lane_we_n` is low.
- R5: A strobe is selecting only when `sel1_n`=0, `sel2`=1 and `sel3_n`=0. A strobe with any other select pattern deselects the block. While deselected, the block performs no writes and `data_oe` goes low within two edges.
- R6: When `oe_n` is high, `data_oe` is low in the same cycle, without waiting for a clock edge.
- R7: The first read issued from a deselected state (including after sleep) keeps `data_oe` low in its output cycle even with `oe_n` low. Later reads drive normally.
- R8: When `linear`=1, each cycle with `adv_n` low steps the low two address bits to start+k mod 4, wrapping, with the upper address bits unchanged.
- R9: When `linear`=0, the k-th beat of a burst uses low address bits start XOR k.
- R10: In a cycle without a strobe, `adv_n` high keeps the current burst address.
- R11: While `sleep` is high, `data_oe` is low and no write takes place. Stored contents are retained across sleep.
- R12: `data_oe` is low in any cycle whose write controls request a write, so the bus acts as an input.
- R13: After reset, `data_oe` is low until a read has been issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of control state |
| adr | input | ADDR_W | Word address |
| strobe_cpu_n | input | 1 | Address strobe, first source, active low |
| strobe_ctl_n | input | 1 | Address strobe, second source, active low |
| adv_n | input | 1 | Burst advance, active low |
| sel1_n | input | 1 | Chip select, active low |
| sel2 | input | 1 | Chip select, active high |
| sel3_n | input | 1 | Chip select, active low |
| gwe_n | input | 1 | Global write, both lanes, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| lane_we_n | input | 2 | Per-lane write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Low-power freeze, active high |
| linear | input | 1 | Burst order: 1 linear, 0 interleaved |
| data_i | input | 18 | Write data from the bus |
| data_o | output | 18 | Registered read data |
| data_oe | output | 1 | Bus drive enable |

## Verification
The hardest situation to reach from the ports is the masked first read after deselect. It needs a selecting strobe to arrive while the block is deselected, and then the output cycle two edges later must be seen as undriven, while the following beat of the same access drives. The stimulus deselects with a strobe carrying a wrong select pattern, lets the pipeline drain, and then issues a selecting read. It checks `data_oe` on each of the next three edges. Sleep reaches the same masked state by another route, and a read after wake repeats the three-edge check. Burst ordering is also exercised by mixing advance and hold cycles inside one burst.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

    localparam int WORD_W = 18;
    localparam int LANES  = 2;
    localparam int LANE_D = 8;

    // Bit mask of one byte lane: eight data bits plus one parity bit above them.
    function automatic logic [WORD_W-1:0] lane_bits(input int k);
        logic [WORD_W-1:0] m;
        m = '0;
        for (int i = 0; i < LANE_D; i++) begin
            m[k*LANE_D + i] = 1'b1;
        end
        m[LANES*LANE_D + k] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/bsram_burst_ctr.sv
module bsram_burst_ctr #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          adv,
    input  logic          linear,
    output logic [CW-1:0] nxt_lsb
);
    typedef struct packed {
        logic [CW-1:0] first;
        logic [CW-1:0] step;
    } ctr_t;

    ctr_t s_d, s_q;
    logic [CW-1:0] cur_lsb;

    function automatic logic [CW-1:0] order(input logic lin, input logic [CW-1:0] f,
                                            input logic [CW-1:0] k);
        return lin ? (f + k) : (f ^ k);
    endfunction

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.first = load_val;
            s_d.step  = '0;
        end else if (adv) begin
            s_d.step = s_q.step + 1'b1;
        end
        nxt_lsb = order(linear, s_d.first, s_d.step);
        cur_lsb = order(linear, s_q.first, s_q.step);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R8
    ctr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cur_lsb == $past(load_val)));

    // R8
    ctr_linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load && linear) |=> (!linear || cur_lsb == $past(cur_lsb) + 1'b1));

    // R10
    ctr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !load) |=> (!$stable(linear) || $stable(cur_lsb)));

endmodule

// File: rtl/bsram_array.sv
module bsram_array #(
    parameter int ADDR_W = 8,
    parameter int WORD_W = bsram_pkg::WORD_W
) (
    input  logic                     clk,
    input  logic [bsram_pkg::LANES-1:0] wr_mask,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [WORD_W-1:0]        wr_data,
    input  logic                     rd_en,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [WORD_W-1:0]        rd_data
);
    import bsram_pkg::*;

    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];
    logic [WORD_W-1:0] keep_m, merged;
    logic [WORD_W-1:0] rd_d, rd_q;

    always_comb begin
        keep_m = '0;
        for (int k = 0; k < LANES; k++) begin
            if (wr_mask[k]) keep_m = keep_m | lane_bits(k);
        end
        merged = (mem[wr_addr] & ~keep_m) | (wr_data & keep_m);
        rd_d   = rd_en ? mem[rd_addr] : rd_q;
    end

    always_ff @(posedge clk) begin
        if (|wr_mask) mem[wr_addr] <= merged;
        rd_q <= rd_d;
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/burst_sram.sv
module burst_sram #(
    parameter int ADDR_W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [ADDR_W-1:0] adr,
    input  logic        strobe_cpu_n,
    input  logic        strobe_ctl_n,
    input  logic        adv_n,
    input  logic        sel1_n,
    input  logic        sel2,
    input  logic        sel3_n,
    input  logic        gwe_n,
    input  logic        bwe_n,
    input  logic [1:0]  lane_we_n,
    input  logic        oe_n,
    input  logic        sleep,
    input  logic        linear,
    input  logic [17:0] data_i,
    output logic [17:0] data_o,
    output logic        data_oe
);
    import bsram_pkg::*;

    localparam int CW   = 2;
    localparam int HI_W = ADDR_W - CW;

    typedef struct packed {
        logic              sel;
        logic [HI_W-1:0]   base;
        logic              s1_v;
        logic              s1_first;
        logic [ADDR_W-1:0] s1_addr;
        logic              ov;
        logic              om;
    } st_t;

    st_t s_d, s_q;

    logic              strobe, cs_all, act, ld, advance, wr_req;
    logic [LANES-1:0]  wmask, arr_mask;
    logic [CW-1:0]     nxt_lsb;
    logic [ADDR_W-1:0] eff_addr;

    bsram_burst_ctr #(.CW(CW)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld),
        .load_val (adr[CW-1:0]),
        .adv      (advance),
        .linear   (linear),
        .nxt_lsb  (nxt_lsb)
    );

    always_comb begin
        strobe  = !sleep && (!strobe_cpu_n || !strobe_ctl_n);
        cs_all  = !sel1_n && sel2 && !sel3_n;
        act     = !sleep && (strobe ? cs_all : s_q.sel);
        wmask   = !gwe_n ? {LANES{1'b1}} : (!bwe_n ? ~lane_we_n : '0);
        wr_req  = |wmask;
        ld      = strobe && cs_all;
        advance = act && !strobe && !adv_n;
        eff_addr = {(ld ? adr[ADDR_W-1:CW] : s_q.base), nxt_lsb};
        arr_mask = act ? wmask : '0;

        s_d          = s_q;
        s_d.sel      = strobe ? cs_all : s_q.sel;
        s_d.base     = ld ? adr[ADDR_W-1:CW] : s_q.base;
        s_d.s1_v     = act && !wr_req;
        s_d.s1_first = !s_q.sel;
        s_d.s1_addr  = eff_addr;
        s_d.ov       = s_q.s1_v;
        s_d.om       = s_q.s1_first;
        if (sleep) begin
            s_d.sel  = 1'b0;
            s_d.s1_v = 1'b0;
            s_d.ov   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    bsram_array #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_arr (
        .clk     (clk),
        .wr_mask (arr_mask),
        .wr_addr (eff_addr),
        .wr_data (data_i),
        .rd_en   (s_q.s1_v && !sleep),
        .rd_addr (s_q.s1_addr),
        .rd_data (data_o)
    );

    assign data_oe = s_q.ov && !s_q.om && !oe_n && !sleep && !wr_req;

    // R1
    read_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.s1_v && !sleep) |=> s_q.ov);

    // R5
    desel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.sel && strobe_cpu_n && strobe_ctl_n) |=> !s_q.s1_v);

    // R11
    sleep_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> !s_q.ov);

endmodule

// File: tb/burst_sram_test.sv
`timescale 1ns/1ps
module burst_sram_test;
    localparam int AW = 8;
    localparam logic [17:0] LANE0 = 18'h100FF;
    localparam logic [17:0] LANE1 = 18'h2FF00;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] adr = '0;
    logic strobe_cpu_n = 1'b1, strobe_ctl_n = 1'b1, adv_n = 1'b1;
    logic sel1_n = 1'b0, sel2 = 1'b1, sel3_n = 1'b0;
    logic gwe_n = 1'b1, bwe_n = 1'b1;
    logic [1:0] lane_we_n = 2'b11;
    logic oe_n = 1'b0, sleep = 1'b0, linear = 1'b1;
    logic [17:0] data_i = '0;
    logic [17:0] data_o;
    logic data_oe;

    int n_run = 0, n_fail = 0;
    logic [17:0] ref_mem [256];

    always #2.5 clk = ~clk;

    burst_sram #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .adr(adr), .strobe_cpu_n(strobe_cpu_n),
        .strobe_ctl_n(strobe_ctl_n), .adv_n(adv_n), .sel1_n(sel1_n), .sel2(sel2),
        .sel3_n(sel3_n), .gwe_n(gwe_n), .bwe_n(bwe_n), .lane_we_n(lane_we_n),
        .oe_n(oe_n), .sleep(sleep), .linear(linear), .data_i(data_i),
        .data_o(data_o), .data_oe(data_oe)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic idle();
        strobe_cpu_n = 1'b1; strobe_ctl_n = 1'b1; adv_n = 1'b1;
        gwe_n = 1'b1; bwe_n = 1'b1; lane_we_n = 2'b11; data_i = '0;
    endtask

    function automatic logic [17:0] merge(input logic [17:0] o, input logic [17:0] n,
                                          input logic [1:0] m);
        logic [17:0] k;
        k = (m[0] ? LANE0 : 18'h0) | (m[1] ? LANE1 : 18'h0);
        return (o & ~k) | (n & k);
    endfunction

    // Strobed write; m is the lane set the requirements say must be written.
    task automatic wr(input logic [AW-1:0] a, input logic [17:0] d, input logic g,
                      input logic b, input logic [1:0] lw, input logic [1:0] m, input bit ctl);
        if (ctl) strobe_ctl_n = 1'b0; else strobe_cpu_n = 1'b0;
        adr = a; gwe_n = g; bwe_n = b; lane_we_n = lw; data_i = d;
        #1;
        if (m != 2'b00) chk(data_oe == 1'b0, "R12 bus released on write", data_oe, 0);
        tick();
        ref_mem[a] = merge(ref_mem[a], d, m);
        idle();
        tick();
    endtask

    task automatic rd(input logic [AW-1:0] a, input string tag);
        strobe_cpu_n = 1'b0; adr = a;
        tick();
        idle();
        tick();
        chk(data_oe && data_o == ref_mem[a], tag, data_o, ref_mem[a]);
    endtask

    task automatic burst(input logic [AW-1:0] start, input logic lin, input logic [2:0] advs,
                         input logic [AW-1:0] e0, input logic [AW-1:0] e1,
                         input logic [AW-1:0] e2, input logic [AW-1:0] e3, input string tag);
        logic [AW-1:0] ex [4];
        ex[0] = e0; ex[1] = e1; ex[2] = e2; ex[3] = e3;
        linear = lin; strobe_ctl_n = 1'b0; adr = start; adv_n = 1'b1;
        tick();
        for (int k = 0; k < 4; k++) begin
            idle();
            adv_n = (k < 3) ? !advs[k] : 1'b1;
            tick();
            chk(data_oe && data_o == ref_mem[ex[k]], tag, data_o, ref_mem[ex[k]]);
        end
        idle();
        linear = 1'b1;
    endtask

    task automatic t_reset();
        tick();
        chk(data_oe == 1'b0, "R13 no drive after reset", data_oe, 0);
    endtask

    task automatic t_latency();
        wr(8'd5, 18'h2A5C3, 1'b0, 1'b1, 2'b11, 2'b11, 0);
        wr(8'd6, 18'h1B00E, 1'b0, 1'b1, 2'b11, 2'b11, 1);
        strobe_cpu_n = 1'b0; adr = 8'd5;
        tick();
        idle();
        chk(data_o == ref_mem[6], "R1 data not early", data_o, ref_mem[6]);
        tick();
        chk(data_oe && data_o == ref_mem[5], "R1 two-edge read", data_o, ref_mem[5]);
    endtask

    task automatic t_lanes();
        wr(8'd5, 18'h3FFFF, 1'b1, 1'b0, 2'b10, 2'b01, 0);
        rd(8'd5, "R2 lane0 only");
        wr(8'd5, 18'h00000, 1'b1, 1'b0, 2'b01, 2'b10, 0);
        rd(8'd5, "R2 lane1 only");
        wr(8'd5, 18'h12345, 1'b0, 1'b0, 2'b11, 2'b11, 0);
        rd(8'd5, "R3 global overrides lane selects");
        wr(8'd5, 18'h3C3C3, 1'b1, 1'b1, 2'b00, 2'b00, 0);
        rd(8'd5, "R4 no write without enables");
    endtask

    task automatic t_oe();
        rd(8'd6, "R6 drive baseline");
        oe_n = 1'b1; #1;
        chk(data_oe == 1'b0, "R6 oe off same cycle", data_oe, 0);
        oe_n = 1'b0; #1;
        chk(data_oe == 1'b1, "R6 oe back on", data_oe, 1);
    endtask

    task automatic t_desel();
        strobe_cpu_n = 1'b0; adr = 8'd5; sel2 = 1'b0; gwe_n = 1'b0; data_i = 18'h0FFFF;
        tick();
        idle(); sel2 = 1'b1;
        tick(); tick();
        chk(data_oe == 1'b0, "R5 no drive while deselected", data_oe, 0);
        strobe_cpu_n = 1'b0; adr = 8'd5;
        tick();
        idle();
        chk(data_oe == 1'b0, "R7 pipeline empty", data_oe, 0);
        tick();
        chk(data_oe == 1'b0, "R7 first read masked", data_oe, 0);
        tick();
        chk(data_oe && data_o == ref_mem[5], "R5 deselected write ignored / R7 next read drives",
            data_o, ref_mem[5]);
    endtask

    task automatic t_bursts();
        for (int i = 8; i < 12; i++) wr(i[AW-1:0], 18'h3A000 + 18'(i * 17), 1'b0, 1'b1, 2'b11, 2'b11, 0);
        burst(8'd10, 1'b1, 3'b111, 8'd10, 8'd11, 8'd8, 8'd9, "R8 linear wrap");
        burst(8'd9, 1'b0, 3'b111, 8'd9, 8'd8, 8'd11, 8'd10, "R9 interleaved order");
        burst(8'd8, 1'b1, 3'b101, 8'd8, 8'd9, 8'd9, 8'd10, "R10 hold on adv_n high");
    endtask

    task automatic t_sleep();
        sleep = 1'b1;
        tick();
        chk(data_oe == 1'b0, "R11 no drive in sleep", data_oe, 0);
        strobe_cpu_n = 1'b0; adr = 8'd9; gwe_n = 1'b0; data_i = 18'h00001;
        tick();
        idle(); tick();
        chk(data_oe == 1'b0, "R11 still quiet", data_oe, 0);
        sleep = 1'b0;
        strobe_cpu_n = 1'b0; adr = 8'd9;
        tick();
        idle(); tick();
        chk(data_oe == 1'b0, "R11 R7 first read after wake masked", data_oe, 0);
        tick();
        chk(data_oe && data_o == ref_mem[9], "R11 contents retained", data_o, ref_mem[9]);
        for (int i = 8; i < 12; i++) rd(i[AW-1:0], "R11 reference compare");
    endtask

    initial begin
        for (int i = 0; i < 256; i++) ref_mem[i] = '0;
        repeat (4) tick();
        rst_n = 1'b1;
        t_reset();
        t_latency();
        t_lanes();
        t_oe();
        t_desel();
        t_bursts();
        t_sleep();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule